// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Front End

This block sits in front of a two-channel digital-to-analog converter. It takes 16-bit command words from a three-wire serial port (active-low select, serial clock, serial data), oversamples those pins with the system clock, and turns each completed word into updates of three 12-bit registers. The three registers are a shared staging buffer, the output latch of channel A and the output latch of channel B. It also keeps a one-bit speed-mode flag.

A host sets channel B alone with one direct write. It can also move both channels at once. First it parks channel B's next code in the staging buffer. Then a single write loads channel A and copies the buffer into channel B in the same cycle. The select line only has to fall once per word. After 16 clocks the port stops listening until select falls again, so a burst-mode host may leave select low between words.

Top module: `sdac_front`

## Requirements
- R1: While reset is asserted and after it is released, both output latches read zero, the mode flag reads 0 and the update pulse is low until a full word arrives.
- R2: A word is 16 bits, sent most significant bit first. Each bit is taken when the serial clock falls while select is low. The low 12 bits (positions 11..0) form the code.
- R3: When bit 15 is 1, channel A's latch takes the code and channel B's latch takes the staging buffer's previous contents in the same update; the staging buffer keeps its value.
- R4: When bit 15 is 0 and bit 12 is 0, the code goes into both the staging buffer and channel B's latch; channel A's latch is unchanged.
- R5: When bit 15 is 0 and bit 12 is 1, only the staging buffer takes the code; both output latches keep their values.
- R6: Every completed word sets the mode flag to its bit 14 (1 = fast, 0 = slow).
- R7: After a select falling edge exactly 16 falling serial clocks are accepted. Further clocks are ignored until the next select falling edge, even if select stays low.
- R8: If select rises before the 16th bit, the partial word is dropped: no register, flag or pulse changes.
- R9: Bit 13 never affects any result, and bit 12 has no effect when bit 15 is 1.
- R10: Each completed word produces an update pulse exactly one system-clock cycle long. New latch and flag values are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low; its falling edge starts a word |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| sdi | input | 1 | Serial data, most significant bit first |
| code_a | output | 12 | Channel A output latch |
| code_b | output | 12 | Channel B output latch |
| fast_mode | output | 1 | Speed-mode flag, 1 = fast |
| upd_pulse | output | 1 | One-cycle marker of a register update |

## Verification
The assertions assume the serial pins move slowly next to the system clock. Each serial-clock level lasts several system cycles, and data stays steady around each falling serial edge. Under that assumption two update pulses cannot fall in adjacent cycles, and the synchronised data bit lines up with the detected clock edge. The stimulus holds each serial-clock phase for four system cycles. It changes data only on the rising serial edge, and it never moves select and the serial clock in the same cycle.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int WORD_W       = 16;
    localparam int CODE_W       = 12;
    localparam int SEL_A_BIT    = 15;
    localparam int SPEED_BIT    = 14;
    localparam int BUF_ONLY_BIT = 12;
    localparam int SYNC_STAGES  = 2;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_A_XFER = 2'd1,  // code -> A, staging -> B
        OP_BUF_B  = 2'd2,  // code -> staging and B
        OP_BUF    = 2'd3   // code -> staging only
    } op_e;

    typedef struct packed {
        op_e               op;
        logic              fast;
        logic [CODE_W-1:0] code;
    } cmd_t;

    function automatic cmd_t decode_word(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.code = w[CODE_W-1:0];
        c.fast = w[SPEED_BIT];
        if (w[SEL_A_BIT])
            c.op = OP_A_XFER;
        else if (w[BUF_ONLY_BIT])
            c.op = OP_BUF;
        else
            c.op = OP_BUF_B;
        return c;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RST_VAL;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= RST_VAL;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
    parameter int WORD_W = sdac_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic              cs_prev_q, sclk_prev_q;
    logic              armed_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shift_q, word_q;
    logic              valid_q;
    logic              cs_fall, sclk_fall;
    logic [WORD_W-1:0] shift_nx;

    assign cs_fall   = cs_prev_q & ~cs_n_s;
    assign sclk_fall = sclk_prev_q & ~sclk_s;
    assign shift_nx  = {shift_q[WORD_W-2:0], sdi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
            armed_q     <= 1'b0;
            cnt_q       <= '0;
            shift_q     <= '0;
            word_q      <= '0;
            valid_q     <= 1'b0;
        end else begin
            cs_prev_q   <= cs_n_s;
            sclk_prev_q <= sclk_s;
            valid_q     <= 1'b0;
            if (cs_n_s) begin
                armed_q <= 1'b0;
            end else if (cs_fall) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (armed_q && sclk_fall) begin
                shift_q <= shift_nx;
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == LAST_IDX) begin
                    armed_q <= 1'b0;
                    word_q  <= shift_nx;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (cnt_q < CNT_W'(WORD_W)));

    // R7
    valid_ends_frame_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (!armed_q && $past(armed_q)));

    // R8
    cs_high_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !armed_q);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o,
    output logic              fast_o,
    output logic              upd_o
);
    cmd_t              cmd;
    logic [CODE_W-1:0] buf_q, lat_a_q, lat_b_q;
    logic              fast_q, upd_q;

    assign cmd = decode_word(word_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q   <= '0;
            lat_a_q <= '0;
            lat_b_q <= '0;
            fast_q  <= 1'b0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= valid_i;
            if (valid_i) begin
                fast_q <= cmd.fast;
                unique case (cmd.op)
                    OP_A_XFER: begin
                        lat_a_q <= cmd.code;
                        lat_b_q <= buf_q;
                    end
                    OP_BUF_B: begin
                        buf_q   <= cmd.code;
                        lat_b_q <= cmd.code;
                    end
                    OP_BUF:  buf_q <= cmd.code;
                    default: ;
                endcase
            end
        end
    end

    assign code_a_o = lat_a_q;
    assign code_b_o = lat_b_q;
    assign fast_o   = fast_q;
    assign upd_o    = upd_q;

    // R10
    upd_single_chk: assert property (@(posedge clk) disable iff (rst)
        upd_q |=> !upd_q);

    // R5
    hold_without_upd_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_q |-> ($stable(lat_a_q) && $stable(lat_b_q) && $stable(fast_q)));

    // R4
    buf_b_match_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cmd.op == OP_BUF_B) |=> (lat_b_q == buf_q));

    // R3
    xfer_keeps_buf_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cmd.op == OP_A_XFER) |=> $stable(buf_q));
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              fast_mode,
    output logic              upd_pulse
);
    logic [2:0]        pins_s;
    logic [WORD_W-1:0] word;
    logic              word_valid;

    sdac_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, sdi}),
        .q   (pins_s)
    );

    sdac_frame_rx #(.WORD_W(WORD_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .cs_n_s  (pins_s[2]),
        .sclk_s  (pins_s[1]),
        .sdi_s   (pins_s[0]),
        .word_o  (word),
        .valid_o (word_valid)
    );

    sdac_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (word_valid),
        .word_i   (word),
        .code_a_o (code_a),
        .code_b_o (code_b),
        .fast_o   (fast_mode),
        .upd_o    (upd_pulse)
    );
endmodule

// File: tb/tb_sdac_front.sv
module tb_sdac_front;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [11:0] code_a, code_b;
    logic        fast_mode, upd_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [11:0] a;
        logic [11:0] b;
        logic        f;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [11:0] m_buf = '0, m_a = '0, m_b = '0;
    logic        m_f = 1'b0;
    logic        prev_upd = 1'b0;

    always #5 clk = ~clk;

    sdac_front dut (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .sdi (sdi),
        .code_a (code_a), .code_b (code_b), .fast_mode (fast_mode),
        .upd_pulse (upd_pulse)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference model for one completed word
    task automatic expect_word(input logic [15:0] w, input string tag);
        exp_t e;
        m_f = w[14];
        if (w[15]) begin
            m_b = m_buf;
            m_a = w[11:0];
        end else if (!w[12]) begin
            m_buf = w[11:0];
            m_b   = w[11:0];
        end else begin
            m_buf = w[11:0];
        end
        e.a = m_a; e.b = m_b; e.f = m_f; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic clock_bits(input logic [15:0] w, input int n);
        for (int i = 15; i > 15 - n; i--) begin
            sdi  = w[i];
            sclk = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b0;
            wait_cyc(HALF);
        end
    endtask

    task automatic frame(input logic [15:0] w, input string tag);
        expect_word(w, tag);
        cs_n = 1'b0;
        wait_cyc(HALF);
        clock_bits(w, 16);
        wait_cyc(2);
        cs_n = 1'b1;
        wait_cyc(HALF * 2);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (upd_pulse && prev_upd)
                chk(1'b0, "R10 pulse longer than one cycle", 16'd1, 16'd0);
            if (upd_pulse && !prev_upd) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8 unexpected update (R7 lockout)", 16'd1, 16'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(code_a == e.a, {e.tag, " code_a"}, {4'h0, code_a}, {4'h0, e.a});
                    chk(code_b == e.b, {e.tag, " code_b"}, {4'h0, code_b}, {4'h0, e.b});
                    chk(fast_mode == e.f, {e.tag, " R6 fast_mode"}, {15'h0, fast_mode}, {15'h0, e.f});
                end
            end
            prev_upd <= upd_pulse;
        end
    end

    initial begin
        wait_cyc(5);
        // R1: reset state
        chk(code_a == 12'h000, "R1 code_a", {4'h0, code_a}, 16'h0);
        chk(code_b == 12'h000, "R1 code_b", {4'h0, code_b}, 16'h0);
        chk(fast_mode == 1'b0, "R1 fast_mode", {15'h0, fast_mode}, 16'h0);
        chk(upd_pulse == 1'b0, "R1 upd_pulse", {15'h0, upd_pulse}, 16'h0);
        rst = 1'b0;
        wait_cyc(10);
        chk(upd_pulse == 1'b0 && code_a == 0 && code_b == 0, "R1 idle after reset",
            {4'h0, code_b}, 16'h0);

        frame(16'h0FFF, "R4 R2 staging+B full scale");
        frame(16'h5ABC, "R5 staging only");
        frame(16'hC800, "R3 A mid-scale, B from staging");
        frame(16'hB123, "R9 D12 ignored with D15 set");
        frame(16'h2345, "R9 D13 ignored");

        // R8: partial word dropped
        cs_n = 1'b0;
        wait_cyc(HALF);
        clock_bits(16'h8FFF, 7);
        cs_n = 1'b1;
        wait_cyc(HALF * 4);
        chk(code_a == 12'h123 && code_b == 12'h345, "R8 partial word no effect",
            {4'h0, code_a}, 16'h0123);

        // R7: burst with select held low, extra clocks ignored
        expect_word(16'h4777, "R7 first word of burst");
        cs_n = 1'b0;
        wait_cyc(HALF);
        clock_bits(16'h4777, 16);
        clock_bits(16'h8FFF, 16);
        wait_cyc(4);
        chk(code_a == 12'h123 && fast_mode == 1'b1, "R7 extra clocks ignored",
            {3'h0, fast_mode, code_a}, 16'h1123);
        cs_n = 1'b1;
        wait_cyc(HALF * 2);

        frame(16'h9000, "R3 transfer after burst");
        frame(16'h1FFF, "R5 staging only, latches hold");
        frame(16'hE555, "R3 R6 fast transfer");

        wait_cyc(20);
        chk(q.size() == 0, "R10 every word produced one update",
            q.size(), 16'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule